// File: doc/BRIEF.md
# Prescaled Seconds Timer with Alarm

A free-running up-counter paced by a slow reference clock and read over a simple 32-bit word-addressed register bus. A 16-bit prescaler divides the slow clock, and each prescaler period advances a 32-bit counter by one. If the prescaler is loaded with the slow clock's frequency, the counter counts seconds. Software cannot load the counter. It can only restart it from zero with a self-clearing command bit.

A 32-bit alarm register is compared with the counter as the counter advances. Two sticky status flags record alarm matches and counter increments, and both clear when the status word is read. Each flag has its own interrupt enable in the mode word. The enables sit sixteen bits above the flags they gate, and the interrupt output is high while any enabled flag is set. The counter lives in the slow clock domain and reaches the bus domain as a Gray-coded value, so a read never returns a torn count.

Top module: `sect_timer`

## Requirements
- R1: After reset the mode word reads 0, the alarm reads 0xFFFFFFFF ("no alarm"), the counter reads 0, the status reads 0 and `irq` is low.
- R2: Word address 2 returns the counter and is read-only. A bus write to it leaves the counter unchanged.
- R3: The mode word's bits 15:0 set the prescaler. The counter advances once every P slow-clock periods, and P = 0 means 65536 periods.
- R4: Writing the mode word (address 0) with bit 18 set restarts the counter and prescaler from zero. Bit 18 always reads back 0, and bits 17:0 take the value written in that same access.
- R5: Successive counter reads never decrease and never skip a value, except across a restart.
- R6: Status bit 1 (address 3) sets on every counter increment.
- R7: Status bit 0 sets on the increment at which the counter becomes equal to the alarm register (address 1).
- R8: A status read returns the flags and clears both. A flag that sets in the same cycle as the read stays set.
- R9: `irq` is high while status bit 0 is set with mode bit 16 set, or while status bit 1 is set with mode bit 17 set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset, used in both domains |
| slow_clk | input | 1 | Slow reference clock that feeds the prescaler |
| sel | input | 1 | Bus access in this cycle |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 2 | Word address: 0 mode, 1 alarm, 2 counter, 3 status |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after the read access |
| irq | output | 1 | Interrupt request |

## Verification
An increment flag being set and a read-to-clear of the status word can land on the same bus edge. With the prescaler at 1, the counter advances about every six bus cycles. The bench then reads status back-to-back every two cycles, so many increments fall on a read edge. It then freezes the counter by loading prescaler 0 and compares the number of increment flags collected with the final counter value. Any flag dropped by a colliding read shows up as a shortfall.

// File: rtl/sect_pkg.sv
// Shared constants for the prescaled seconds timer: bus geometry, word
// addresses of the four registers, and bit positions inside the mode and
// status words. Field positions matter because the interrupt gate lines the
// enables (bits 17:16) up with the flags (bits 1:0) by a 16-bit shift.
package sect_pkg;
    localparam int BUS_W  = 32;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_MODE   = 2'd0;
    localparam logic [ADDR_W-1:0] A_ALARM  = 2'd1;
    localparam logic [ADDR_W-1:0] A_VALUE  = 2'd2;
    localparam logic [ADDR_W-1:0] A_STATUS = 2'd3;

    localparam int MB_ALM_IE  = 16;
    localparam int MB_INC_IE  = 17;
    localparam int MB_RESTART = 18;

    localparam int SB_ALM = 0;
    localparam int SB_INC = 1;

    typedef logic [1:0] evt_t;
endpackage

// File: rtl/sect_sync.sv
// Multi-stage synchronizer into the domain of clk. With GRAY_DECODE = 1 the
// vector is taken to be Gray coded and is returned as binary after the last
// stage. Assumes the source changes at most one bit per destination sample
// window when W > 1 (Gray counter) or is a single toggling bit.
module sect_sync #(
    parameter int W           = 1,
    parameter int STAGES      = 2,
    parameter bit GRAY_DECODE = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg_q;

    // First stage samples the foreign-domain input.
    always_ff @(posedge clk) begin
        if (!rst_n) stg_q[0] <= '0;
        else        stg_q[0] <= d;
    end

    genvar gs;
    generate
        for (gs = 1; gs < STAGES; gs++) begin : g_stage
            // Each further stage settles the previous one.
            always_ff @(posedge clk) begin
                if (!rst_n) stg_q[gs] <= '0;
                else        stg_q[gs] <= stg_q[gs-1];
            end
        end

        if (GRAY_DECODE) begin : g_gray
            // Gray to binary: each bit is the parity of itself and all above.
            always_comb begin
                for (int i = 0; i < W; i++) q[i] = ^(stg_q[STAGES-1] >> i);
            end
        end else begin : g_plain
            assign q = stg_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/sect_slow_core.sv
// Slow-domain engine: prescaler and up-counter, clocked by slow_clk.
// A restart request arrives as a synchronized toggle. The core acknowledges
// it by copying the toggle, and in that same edge zeroes the prescaler and
// the counter. The counter is published as a registered Gray code so that
// the bus side can sample it safely. Assumes presc is quasi-static: software
// changes it together with a restart, or accepts one irregular period.
module sect_slow_core #(
    parameter int PRE_W = 16,
    parameter int CNT_W = 32
) (
    input  logic             slow_clk,
    input  logic             rst_n,
    input  logic [PRE_W-1:0] presc,
    input  logic             req_sync,
    output logic [CNT_W-1:0] cnt_gray,
    output logic             ack_tgl
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] pre_last;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;
    logic             restart;
    logic             period_end;

    // Last prescaler count of a period; 0 wraps to all ones (2^PRE_W periods).
    assign pre_last   = presc - PRE_W'(1);
    assign period_end = (pre_q == pre_last);
    assign restart    = (req_sync != ack_tgl);
    assign cnt_inc    = cnt_q + CNT_W'(1);

    // Prescaler, counter, Gray image and restart acknowledge.
    always_ff @(posedge slow_clk) begin
        if (!rst_n) begin
            pre_q    <= '0;
            cnt_q    <= '0;
            cnt_gray <= '0;
            ack_tgl  <= 1'b0;
        end else begin
            ack_tgl <= req_sync;
            if (restart) begin
                pre_q    <= '0;
                cnt_q    <= '0;
                cnt_gray <= '0;
            end else if (period_end) begin
                pre_q    <= '0;
                cnt_q    <= cnt_inc;
                cnt_gray <= cnt_inc ^ (cnt_inc >> 1);
            end else begin
                pre_q <= pre_q + PRE_W'(1);
            end
        end
    end
endmodule

// File: rtl/sect_regs.sv
// Bus-domain register file and event logic. It holds the mode and alarm
// words, the bus view of the counter, and the two sticky status flags.
// An increment is seen when the synchronized counter differs from the
// view. Assumes clk is fast enough that the counter never moves twice
// between two bus samples. After a restart write the view is forced to 0
// and events are masked until the slow side acknowledges, plus one settle
// cycle.
module sect_regs
    import sect_pkg::*;
#(
    parameter int PRE_W = 16,
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    output logic [BUS_W-1:0]  rdata,
    output logic              irq,
    input  logic [CNT_W-1:0]  cnt_bin,
    input  logic              ack_sync,
    output logic [PRE_W-1:0]  presc,
    output logic              req_tgl,
    output logic [CNT_W-1:0]  view_o,
    output logic [CNT_W-1:0]  alarm_o,
    output evt_t              status_o,
    output logic              inc_evt_o,
    output logic              pending_o
);
    logic [PRE_W-1:0] presc_q;
    logic             alm_ie_q;
    logic             inc_ie_q;
    logic [CNT_W-1:0] alarm_q;
    logic [CNT_W-1:0] view_q;
    evt_t             evt_q;
    logic             req_q;
    logic             pending_q;
    logic             settle_q;

    logic             wr_mode;
    logic             wr_alarm;
    logic             rd_any;
    logic             rd_stat;
    logic             restart_wr;
    logic             inc_evt;
    logic             alm_evt;
    logic             ack_match;
    logic [BUS_W-1:0] mode_word;
    evt_t             en_bits;
    evt_t             evt_set;

    assign wr_mode    = sel & wr & (addr == A_MODE);
    assign wr_alarm   = sel & wr & (addr == A_ALARM);
    assign rd_any     = sel & ~wr;
    assign rd_stat    = rd_any & (addr == A_STATUS);
    assign restart_wr = wr_mode & wdata[MB_RESTART];
    assign ack_match  = (ack_sync == req_q);

    // Event detection against the bus view of the counter.
    assign inc_evt = ~pending_q & ~restart_wr & (cnt_bin != view_q);
    assign alm_evt = inc_evt & (cnt_bin == alarm_q);

    // Readable image of the mode word; the restart bit is never stored.
    always_comb begin
        mode_word                 = '0;
        mode_word[PRE_W-1:0]      = presc_q;
        mode_word[MB_ALM_IE]      = alm_ie_q;
        mode_word[MB_INC_IE]      = inc_ie_q;
    end

    // Enables shifted down onto the flag positions.
    assign en_bits = evt_t'(mode_word >> MB_ALM_IE);

    always_comb begin
        evt_set         = '0;
        evt_set[SB_ALM] = alm_evt;
        evt_set[SB_INC] = inc_evt;
    end

    // Mode and alarm registers, written by the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            presc_q  <= '0;
            alm_ie_q <= 1'b0;
            inc_ie_q <= 1'b0;
            alarm_q  <= '1;
        end else begin
            if (wr_mode) begin
                presc_q  <= wdata[PRE_W-1:0];
                alm_ie_q <= wdata[MB_ALM_IE];
                inc_ie_q <= wdata[MB_INC_IE];
            end
            if (wr_alarm) alarm_q <= wdata[CNT_W-1:0];
        end
    end

    // Restart request toggle and the masking window until acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q     <= 1'b0;
            pending_q <= 1'b0;
            settle_q  <= 1'b0;
        end else if (restart_wr) begin
            req_q     <= ~req_q;
            pending_q <= 1'b1;
            settle_q  <= 1'b0;
        end else if (pending_q && settle_q) begin
            pending_q <= 1'b0;
            settle_q  <= 1'b0;
        end else if (pending_q && ack_match) begin
            settle_q  <= 1'b1;
        end
    end

    // Bus view of the counter: zero while a restart is in flight.
    always_ff @(posedge clk) begin
        if (!rst_n)                      view_q <= '0;
        else if (restart_wr || pending_q) view_q <= '0;
        else                             view_q <= cnt_bin;
    end

    // Sticky flags: a read clears, a same-cycle event wins.
    always_ff @(posedge clk) begin
        if (!rst_n) evt_q <= '0;
        else        evt_q <= (evt_q & ~(rd_stat ? 2'b11 : 2'b00)) | evt_set;
    end

    // Registered read data, one cycle after the access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_any) begin
            unique case (addr)
                A_MODE:   rdata <= mode_word;
                A_ALARM:  rdata <= BUS_W'(alarm_q);
                A_VALUE:  rdata <= BUS_W'(view_q);
                default:  rdata <= BUS_W'(evt_q);
            endcase
        end
    end

    assign irq       = |(evt_q & en_bits);
    assign presc     = presc_q;
    assign req_tgl   = req_q;
    assign view_o    = view_q;
    assign alarm_o   = alarm_q;
    assign status_o  = evt_q;
    assign inc_evt_o = inc_evt;
    assign pending_o = pending_q;
endmodule

// File: rtl/sect_timer.sv
// Top of the prescaled seconds timer. Joins the slow-domain counter engine
// to the bus-domain register file through three synchronizers: the Gray
// counter and the restart acknowledge into clk, and the restart request
// into slow_clk. rst_n must be held for several periods of both clocks.
module sect_timer
    import sect_pkg::*;
#(
    parameter int PRE_W  = 16,
    parameter int CNT_W  = 32,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_clk,
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    output logic [BUS_W-1:0]  rdata,
    output logic              irq
);
    logic [PRE_W-1:0] presc_w;
    logic             req_tgl_w;
    logic             req_sync_w;
    logic             ack_tgl_w;
    logic             ack_sync_w;
    logic [CNT_W-1:0] cnt_gray_w;
    logic [CNT_W-1:0] cnt_bin_w;
    logic [CNT_W-1:0] view_w;
    logic [CNT_W-1:0] alarm_w;
    evt_t             status_w;
    logic             inc_evt_w;
    logic             pending_w;

    sect_sync #(.W(1), .STAGES(STAGES), .GRAY_DECODE(1'b0)) u_req_sync (
        .clk(slow_clk), .rst_n(rst_n), .d(req_tgl_w), .q(req_sync_w)
    );

    sect_slow_core #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_core (
        .slow_clk(slow_clk), .rst_n(rst_n), .presc(presc_w),
        .req_sync(req_sync_w), .cnt_gray(cnt_gray_w), .ack_tgl(ack_tgl_w)
    );

    sect_sync #(.W(CNT_W), .STAGES(STAGES), .GRAY_DECODE(1'b1)) u_cnt_sync (
        .clk(clk), .rst_n(rst_n), .d(cnt_gray_w), .q(cnt_bin_w)
    );

    sect_sync #(.W(1), .STAGES(STAGES), .GRAY_DECODE(1'b0)) u_ack_sync (
        .clk(clk), .rst_n(rst_n), .d(ack_tgl_w), .q(ack_sync_w)
    );

    sect_regs #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq), .cnt_bin(cnt_bin_w),
        .ack_sync(ack_sync_w), .presc(presc_w), .req_tgl(req_tgl_w),
        .view_o(view_w), .alarm_o(alarm_w), .status_o(status_w),
        .inc_evt_o(inc_evt_w), .pending_o(pending_w)
    );
endmodule

// File: rtl/sect_timer_chk.sv
// Property checker for sect_timer, attached by bind. It watches the bus
// ports and the register file's view, alarm, status and event signals.
module sect_timer_chk
    import sect_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel,
    input logic              wr,
    input logic [ADDR_W-1:0] addr,
    input logic [BUS_W-1:0]  rdata,
    input logic              irq,
    input logic [CNT_W-1:0]  view,
    input logic [CNT_W-1:0]  alarm,
    input evt_t              status,
    input logic              inc_evt,
    input logic              pending
);
    // R5: outside a restart the view holds or steps by exactly one.
    a_r5_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        (!pending && !$past(pending)) |-> (view == $past(view) || view == $past(view) + CNT_W'(1)));

    // R6: a fresh increment flag comes with a change of the view.
    a_r6_inc_moves_view: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[SB_INC]) |-> (view != $past(view)));

    // R7: a fresh alarm flag means the view just reached the alarm value.
    a_r7_alarm_at_match: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[SB_ALM]) |-> (view == $past(alarm)));

    // R4: the restart bit never reads back as 1.
    a_r4_restart_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !wr && addr == A_MODE) |=> !rdata[MB_RESTART]);

    // R8: a status read with no event in that cycle leaves both flags clear.
    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !wr && addr == A_STATUS && !inc_evt) |=> (status == 2'b00));

    // R9: the interrupt is never raised without a pending flag.
    a_r9_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status != 2'b00));
endmodule

bind sect_timer sect_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .addr(addr),
    .rdata(rdata), .irq(irq), .view(view_w), .alarm(alarm_w),
    .status(status_w), .inc_evt(inc_evt_w), .pending(pending_w)
);

// File: tb/sim_sect_timer.sv
// Scoreboard bench: bus_rd pushes the expected word into a queue, and a
// monitor pops it when the registered read data is valid and compares it.
module sim_sect_timer;
    import sect_pkg::*;

    logic              clk = 1'b0;
    logic              slow_clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sel = 1'b0;
    logic              wr = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [BUS_W-1:0]  wdata = '0;
    logic [BUS_W-1:0]  rdata;
    logic              irq;

    int checks = 0;
    int errors = 0;
    logic [31:0] last_rd = '0;
    logic        rd_seen = 1'b0;

    logic [31:0] q_exp[$];
    logic [31:0] q_mask[$];
    string       q_tag[$];

    always #10 clk = ~clk;        // 50 MHz bus clock
    always #65 slow_clk = ~slow_clk;

    sect_timer u0 (
        .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .sel(sel), .wr(wr),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    // Marks the cycle after a read access, when rdata holds the result.
    always @(posedge clk) rd_seen <= sel && !wr;

    // Monitor: pop the expected item and compare against rdata.
    always @(negedge clk) begin
        logic [31:0] e;
        logic [31:0] m;
        string       t;
        if (rd_seen) begin
            last_rd = rdata;
            if (q_exp.size() == 0) begin
                checks++; errors++;
                $display("FAIL scoreboard: read with no expected item, actual=%h expected=none", rdata);
            end else begin
                e = q_exp.pop_front(); m = q_mask.pop_front(); t = q_tag.pop_front();
                if (m != 0) begin
                    checks++;
                    if ((rdata & m) != (e & m)) begin
                        errors++;
                        $display("FAIL %s: actual=%h expected=%h mask=%h", t, rdata, e, m);
                    end
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [ADDR_W-1:0] a, input logic [31:0] e,
                          input logic [31:0] m, input string tag, output logic [31:0] d);
        @(negedge clk);
        q_exp.push_back(e); q_mask.push_back(m); q_tag.push_back(tag);
        sel = 1'b1; wr = 1'b0; addr = a;
        @(negedge clk);
        sel = 1'b0;
        #1 d = last_rd;
    endtask

    task automatic wait_value(input logic [31:0] tgt, input string tag);
        logic [31:0] v;
        bit hit = 0;
        for (int n = 0; n < 5000; n++) begin
            bus_rd(A_VALUE, 0, 0, "poll", v);
            if (v == tgt) begin hit = 1; break; end
        end
        if (!hit) chk(0, tag, v, tgt);
    endtask

    // Watchdog: a hung run ends as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] prev;
        realtime t1, t2;
        int ninc;
        bit mono;

        repeat (20) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        bus_rd(A_MODE,   32'h0,        '1, "R1 mode reset",   v);
        bus_rd(A_ALARM,  32'hFFFF_FFFF, '1, "R1 alarm reset", v);
        bus_rd(A_VALUE,  32'h0,        '1, "R1 counter reset", v);
        bus_rd(A_STATUS, 32'h0,        '1, "R1 status reset", v);
        chk(irq == 1'b0, "R1 irq reset", irq, 0);

        // R3: prescaler 0 means 65536 periods, so no step for a long while
        repeat (1000) @(negedge clk);
        bus_rd(A_VALUE, 32'h0, '1, "R3 prescaler zero holds", v);

        // R4: restart with enables and prescaler 5; bit 18 reads back 0
        bus_wr(A_MODE, 32'h0007_0005);
        bus_rd(A_MODE, 32'h0003_0005, '1, "R4 mode readback", v);

        // R2: counter register ignores writes
        bus_wr(A_VALUE, 32'h1234_5678);
        bus_rd(A_VALUE, 0, 0, "R2", v);
        chk(v < 2, "R2 counter not writable", v, 0);

        // R3: four increments at prescaler 5 take 20 slow periods (2600 ns)
        wait_value(1, "R3 reach 1");
        t1 = $realtime;
        wait_value(5, "R3 reach 5");
        t2 = $realtime;
        chk((t2 - t1) > 2440.0 && (t2 - t1) < 2760.0, "R3 prescaler period",
            32'(int'(t2 - t1)), 2600);

        // R4: restart zeroes the running counter
        bus_wr(A_MODE, 32'h0004_0005);
        repeat (30) @(negedge clk);
        bus_rd(A_VALUE, 32'h0, '1, "R4 restart zeroes counter", v);

        // R5: reads never decrease nor skip at prescaler 1
        bus_wr(A_MODE, 32'h0004_0001);
        bus_rd(A_VALUE, 0, 0, "R5", prev);
        mono = 1;
        for (int i = 0; i < 80; i++) begin
            bus_rd(A_VALUE, 0, 0, "R5", v);
            if (!(v == prev || v == prev + 1)) mono = 0;
            prev = v;
        end
        chk(mono, "R5 monotonic reads", prev, 0);
        chk(prev > 5, "R5 counter advancing", prev, 6);

        // R6 R7 R9: alarm at 3, only the alarm interrupt enabled, prescaler 3
        bus_wr(A_ALARM, 32'd3);
        bus_wr(A_MODE, 32'h0005_0003);
        bus_rd(A_STATUS, 0, 0, "clear", v);
        wait_value(2, "R6 reach 2");
        chk(irq == 1'b0, "R9 increment flag without enable", irq, 0);
        bus_rd(A_STATUS, 32'h2, 32'h3, "R6 R7 flags at count 2", v);
        wait_value(3, "R7 reach 3");
        chk(irq == 1'b1, "R9 alarm interrupt", irq, 1);
        bus_rd(A_STATUS, 32'h3, 32'h3, "R7 alarm flag at match", v);
        chk(irq == 1'b0, "R9 irq drops after read", irq, 0);
        bus_rd(A_STATUS, 32'h0, 32'h1, "R8 alarm flag cleared", v);
        bus_wr(A_MODE, 32'h0002_0003);
        wait_value(5, "R9 reach 5");
        chk(irq == 1'b1, "R9 increment interrupt", irq, 1);

        // R8: collisions of increments with back-to-back status reads
        bus_wr(A_MODE, 32'h0004_0001);
        bus_rd(A_STATUS, 0, 0, "clear", v);
        ninc = 0;
        for (int i = 0; i < 100; i++) begin
            bus_rd(A_STATUS, 0, 0, "R8", v);
            ninc += int'(v[SB_INC]);
        end
        bus_wr(A_MODE, 32'h0000_0000);
        repeat (30) @(negedge clk);
        bus_rd(A_VALUE, 0, 0, "R8", prev);
        bus_rd(A_STATUS, 0, 0, "R8", v);
        ninc += int'(v[SB_INC]);
        chk(prev > 10, "R8 counter ran", prev, 11);
        chk(ninc == int'(prev), "R8 no flag lost on read collision", ninc, prev);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule